// File: doc/BRIEF.md
# High-Speed Lane Sync Byte Aligner

This block sits behind the bit sampler of one high-speed receive lane. It takes one serial bit per clock, together with an enable that the lane state tracker holds high for the whole of a high-speed burst. Each burst opens with a run of zero bits of unknown length. The block must let that run pass without output. It then looks for the leader byte 00011101 and locks its byte boundary to the end of that leader. From that point every eight enabled bits are gathered into one payload byte, which is presented with a one-cycle valid strobe.

Each lane carries its own copy of the block, and the lanes do not share alignment. When the enable falls, the burst is over. The lock is then dropped, any byte that was only partly received is thrown away, and the next burst must find its own leader. If the zero run has clearly ended and no leader appears within a bounded number of bits, the block raises a sync-error flag. The flag stays up for the rest of that burst.

Top module: `sync_byte_aligner`

## Requirements
- R1: While reset is held and in the first cycle after it is released, `byteValid`, `syncFound` and `syncErr` are 0 and `byteOut` is 0.
- R2: The leader is the 8-bit value 0x1D, received first bit first (0,0,0,1,1,1,0,1). The search window is filled with ones at the start of every burst, so a lock needs three received zeros before the 11101. `syncFound` rises in the cycle after the last leader bit is sampled.
- R3: While the block is unlocked, including during the leading zero run, `byteValid` stays 0.
- R4: The first bit after the leader becomes bit 0 of the first byte, and each later bit fills the next higher bit. `byteValid` is high for exactly the one cycle after the 8th bit of a byte is sampled. `byteOut` then holds that byte until the next byte completes.
- R5: While the block is locked and enabled, a byte completes every 8 enabled bits. A copy of the leader value inside the payload does not change the alignment, and `syncFound` stays 1.
- R6: When `serEn` is low at a clock edge, `syncFound` and `syncErr` are 0 in the next cycle. Any partly received byte is discarded and produces no `byteValid`, and the next burst must lock again.
- R7: While hunting, bits are counted from the first received 1 of the burst, with that 1 counted as bit 1. If the 32nd counted bit does not complete the leader, `syncErr` rises in the cycle after it. The flag stays 1 until `serEn` goes low, and the search continues.
- R8: A leader that completes on exactly the 32nd counted bit locks the lane and raises no sync error.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit-rate clock |
| rstN | input | 1 | Synchronous reset, active low |
| serEn | input | 1 | High-speed receive enable from the lane state tracker |
| serBit | input | 1 | Serial data bit, sampled when serEn is high |
| byteOut | output | 8 | Most recent aligned payload byte, bit 0 received first |
| byteValid | output | 1 | One-cycle strobe marking a new byteOut |
| syncFound | output | 1 | Leader found; byte alignment locked for this burst |
| syncErr | output | 1 | No leader within the bit limit after the zero run |

## Verification
The bench probes several corner cases.
- A lone 11101 right after enable must not lock. A design that preloaded its window with zeros would lock falsely there.
- A leader value inside the payload must not move the byte boundary. A design that kept searching after lock would realign and corrupt the bytes that follow.
- The enable is dropped partway through a byte. A design that kept a partial byte would emit a stale strobe or carry the bits into the next burst.
- A leader that finishes on exactly the 32nd counted bit must lock without an error. A timeout counter that is off by one either misses the error or flags a good burst.
- Random bursts with varied zero runs, garbage before the leader and truncated payloads are checked cycle by cycle against a bench model.

// File: rtl/sba_pkg.sv
package sba_pkg;
  // Strobes from the control FSM to the datapath, one set per clock
  typedef struct packed {
    logic clearAll;   // burst over: restore window, drop partial byte
    logic huntShift;  // shift the bit into the leader search window
    logic payShift;   // shift the bit into the payload byte accumulator
  } sbaStrobe_t;
endpackage

// File: rtl/sba_datapath.sv
module sba_datapath
  import sba_pkg::*;
#(
  parameter int SYNC_W = 8,
  parameter logic [SYNC_W-1:0] SYNC_PATTERN = 8'b0001_1101,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              serBit,
  input  sbaStrobe_t        strobe,
  output logic              matchHit,
  output logic [BYTE_W-1:0] byteOut,
  output logic              byteValid
);
  localparam int CNT_W = (BYTE_W > 1) ? $clog2(BYTE_W) : 1;
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

  logic [SYNC_W-1:0] huntReg;
  logic [SYNC_W-1:0] huntNext;
  logic [BYTE_W-1:0] accReg;
  logic [BYTE_W-1:0] accNext;
  logic [CNT_W-1:0]  bitCnt;
  logic              byteLast;

  // Earliest bit sits at the top of the window, so it lines up with the pattern MSB
  assign huntNext = {huntReg[SYNC_W-2:0], serBit};
  assign matchHit = strobe.huntShift && (huntNext == SYNC_PATTERN);

  // Payload arrives low bit first: new bits enter at the top and move down
  assign accNext  = {serBit, accReg[BYTE_W-1:1]};
  assign byteLast = (bitCnt == LAST_BIT);

  // Search window: all ones at burst start so no zeros are assumed
  always_ff @(posedge clk) begin
    if (!rstN || strobe.clearAll) begin
      huntReg <= '1;
    end else if (strobe.huntShift) begin
      huntReg <= huntNext;
    end
  end

  // Byte accumulator and bit position within the current byte
  always_ff @(posedge clk) begin
    if (!rstN || strobe.clearAll || strobe.huntShift) begin
      accReg <= '0;
      bitCnt <= '0;
    end else if (strobe.payShift) begin
      accReg <= accNext;
      bitCnt <= byteLast ? '0 : bitCnt + 1'b1;
    end
  end

  // Output register and strobe
  always_ff @(posedge clk) begin
    if (!rstN) begin
      byteOut   <= '0;
      byteValid <= 1'b0;
    end else begin
      byteValid <= strobe.payShift && byteLast;
      if (strobe.payShift && byteLast) begin
        byteOut <= accNext;
      end
    end
  end

  AST_NO_VALID_WHILE_HUNTING: assert property (@(posedge clk) disable iff (!rstN)
    strobe.huntShift |=> !byteValid); // R3

  AST_VALID_SPACING: assert property (@(posedge clk) disable iff (!rstN)
    byteValid |=> !byteValid); // R4

  AST_CLEAR_NO_VALID: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clearAll |=> !byteValid); // R6
endmodule

// File: rtl/sba_control.sv
module sba_control
  import sba_pkg::*;
#(
  parameter int ERR_LIMIT = 32
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       serEn,
  input  logic       serBit,
  input  logic       matchHit,
  output sbaStrobe_t strobe,
  output logic       syncFound,
  output logic       syncErr
);
  localparam int CNT_W = $clog2(ERR_LIMIT + 1);
  localparam logic [CNT_W-1:0] LAST_COUNT = CNT_W'(ERR_LIMIT - 1);

  typedef enum logic { ST_HUNT, ST_LOCK } state_t;

  state_t           state;
  logic             seenOne;
  logic [CNT_W-1:0] errCnt;
  logic             countBit;

  always_comb begin
    strobe.clearAll  = !serEn;
    strobe.huntShift = serEn && (state == ST_HUNT);
    strobe.payShift  = serEn && (state == ST_LOCK);
  end

  // A bit counts toward the timeout once the zero run has ended
  assign countBit = strobe.huntShift && !matchHit && !syncErr && (seenOne || serBit);

  always_ff @(posedge clk) begin
    if (!rstN || !serEn) begin
      state   <= ST_HUNT;
      seenOne <= 1'b0;
      errCnt  <= '0;
      syncErr <= 1'b0;
    end else if (state == ST_HUNT) begin
      if (matchHit) begin
        state <= ST_LOCK;
      end else if (countBit) begin
        seenOne <= 1'b1;
        errCnt  <= errCnt + 1'b1;
        if (errCnt == LAST_COUNT) begin
          syncErr <= 1'b1;
        end
      end
    end
  end

  assign syncFound = (state == ST_LOCK);

  AST_LOCK_FROM_MATCH: assert property (@(posedge clk) disable iff (!rstN)
    $rose(syncFound) |-> $past(matchHit)); // R2

  AST_LOCK_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (syncFound && serEn) |=> syncFound); // R5

  AST_DROP_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    !serEn |=> (!syncFound && !syncErr)); // R6

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (syncErr && serEn) |=> syncErr); // R7
endmodule

// File: rtl/sync_byte_aligner.sv
module sync_byte_aligner
  import sba_pkg::*;
#(
  parameter int SYNC_W = 8,
  parameter logic [SYNC_W-1:0] SYNC_PATTERN = 8'b0001_1101,
  parameter int BYTE_W = 8,
  parameter int ERR_LIMIT = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              serEn,
  input  logic              serBit,
  output logic [BYTE_W-1:0] byteOut,
  output logic              byteValid,
  output logic              syncFound,
  output logic              syncErr
);
  sbaStrobe_t strobe;
  logic       matchHit;

  sba_control #(
    .ERR_LIMIT (ERR_LIMIT)
  ) u_ctl (
    .clk       (clk),
    .rstN      (rstN),
    .serEn     (serEn),
    .serBit    (serBit),
    .matchHit  (matchHit),
    .strobe    (strobe),
    .syncFound (syncFound),
    .syncErr   (syncErr)
  );

  sba_datapath #(
    .SYNC_W       (SYNC_W),
    .SYNC_PATTERN (SYNC_PATTERN),
    .BYTE_W       (BYTE_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .serBit    (serBit),
    .strobe    (strobe),
    .matchHit  (matchHit),
    .byteOut   (byteOut),
    .byteValid (byteValid)
  );

  AST_VALID_NEEDS_LOCK: assert property (@(posedge clk) disable iff (!rstN)
    byteValid |-> syncFound); // R3
endmodule

// File: tb/sim_sync_byte_aligner.sv
module sim_sync_byte_aligner;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       serEn = 1'b0;
  logic       serBit = 1'b0;
  logic [7:0] byteOut;
  logic       byteValid, syncFound, syncErr;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  string phaseTag = "R1";

  // Bench model state
  logic       mLock, mSeen, mErr, mValid;
  logic [7:0] mHunt, mAcc, mByte;
  int         mCnt, mBits;

  localparam logic [7:0] LEADER = 8'h1D;

  always #5 clk = ~clk;

  sync_byte_aligner u0 (
    .clk(clk), .rstN(rstN), .serEn(serEn), .serBit(serBit),
    .byteOut(byteOut), .byteValid(byteValid), .syncFound(syncFound), .syncErr(syncErr)
  );

  task automatic modelReset();
    mLock = 0; mSeen = 0; mErr = 0; mValid = 0;
    mHunt = 8'hFF; mAcc = 0; mCnt = 0; mBits = 0;
  endtask

  task automatic modelStep(input logic en, input logic b);
    logic [7:0] nh;
    if (!en) begin
      mLock = 0; mSeen = 0; mErr = 0; mValid = 0; mHunt = 8'hFF; mCnt = 0; mBits = 0;
    end else if (!mLock) begin
      mValid = 0;
      nh = {mHunt[6:0], b};
      if (nh == LEADER) begin
        mLock = 1; mBits = 0;
      end else if (!mErr && (mSeen || b)) begin
        mSeen = 1; mCnt++;
        if (mCnt == 32) mErr = 1;
      end
      mHunt = nh;
    end else begin
      mAcc = {b, mAcc[7:1]};
      if (mBits == 7) begin
        mByte = mAcc; mValid = 1; mBits = 0;
      end else begin
        mValid = 0; mBits++;
      end
    end
  endtask

  task automatic checkVal(input string tag, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h at cycle %0d", tag, what, act, exp, cycles);
    end
  endtask

  task automatic compareAll();
    checkVal(phaseTag, "syncFound", int'(syncFound), int'(mLock));
    checkVal(phaseTag, "syncErr", int'(syncErr), int'(mErr));
    checkVal(phaseTag, "byteValid", int'(byteValid), int'(mValid));
    checkVal(phaseTag, "byteOut", int'(byteOut), int'(mByte));
  endtask

  // One bit per cycle: drive at negedge, model at posedge, compare at next negedge
  task automatic sendBit(input logic en, input logic b);
    serEn = en; serBit = b;
    @(posedge clk);
    modelStep(en, b);
    @(negedge clk);
    compareAll();
  endtask

  task automatic sendLeader();
    for (int i = 7; i >= 0; i--) sendBit(1'b1, LEADER[i]);
  endtask

  task automatic sendByte(input logic [7:0] v);
    for (int i = 0; i < 8; i++) sendBit(1'b1, v[i]);
  endtask

  task automatic sendZeros(input int n);
    for (int i = 0; i < n; i++) sendBit(1'b1, 1'b0);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) sendBit(1'b0, 1'b0);
  endtask

  task automatic finishRun();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  // Watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=%0d expected<150000", cycles);
      finishRun();
    end
  end

  initial begin
    int unsigned seed;
    seed = 32'd4711;
    void'($urandom(seed));
    modelReset();
    mByte = 0;

    // R1: reset state
    repeat (3) @(negedge clk);
    phaseTag = "R1";
    compareAll();
    rstN = 1'b1;
    @(negedge clk);
    compareAll();

    // R3: zero run gives no output
    phaseTag = "R3";
    sendZeros(12);
    checkVal("R3", "no lock in zero run", int'(syncFound), 0);

    // R2: leader locks
    phaseTag = "R2";
    sendLeader();
    checkVal("R2", "syncFound after leader", int'(syncFound), 1);

    // R4: LSB-first byte
    phaseTag = "R4";
    sendByte(8'hA5);
    checkVal("R4", "byteOut first byte", int'(byteOut), 8'hA5);
    checkVal("R4", "byteValid pulse", int'(byteValid), 1);
    sendBit(1'b1, 1'b0);
    checkVal("R4", "byteValid one cycle", int'(byteValid), 0);
    checkVal("R4", "byteOut held", int'(byteOut), 8'hA5);

    // R5: leader value in payload does not realign (7 bits left of current byte)
    phaseTag = "R5";
    for (int i = 1; i < 8; i++) sendBit(1'b1, 1'b1);
    sendByte(8'h1D);
    sendByte(8'h00);
    sendByte(8'h3C);
    checkVal("R5", "byte after in-payload leader", int'(byteOut), 8'h3C);

    // R6: drop mid-byte
    phaseTag = "R6";
    sendBit(1'b1, 1'b1); sendBit(1'b1, 1'b0); sendBit(1'b1, 1'b1);
    idle(1);
    checkVal("R6", "syncFound after drop", int'(syncFound), 0);
    checkVal("R6", "no valid from partial", int'(byteValid), 0);
    idle(2);
    checkVal("R6", "byteOut unchanged", int'(byteOut), 8'h3C);

    // R2: 11101 alone right after enable must not lock
    phaseTag = "R2";
    sendBit(1'b1, 1); sendBit(1'b1, 1); sendBit(1'b1, 1); sendBit(1'b1, 0); sendBit(1'b1, 1);
    checkVal("R2", "no lock without zeros", int'(syncFound), 0);
    idle(2);

    // R7: zeros then 32 ones -> error, sticky
    phaseTag = "R7";
    sendZeros(5);
    for (int i = 0; i < 31; i++) sendBit(1'b1, 1'b1);
    checkVal("R7", "no error before 32nd bit", int'(syncErr), 0);
    sendBit(1'b1, 1'b1);
    checkVal("R7", "error after 32nd bit", int'(syncErr), 1);
    sendZeros(4);
    checkVal("R7", "error sticky", int'(syncErr), 1);
    idle(1);
    checkVal("R7", "error cleared by drop", int'(syncErr), 0);
    idle(1);

    // R8: leader completing on 32nd counted bit
    phaseTag = "R8";
    sendZeros(6);
    for (int i = 0; i < 24; i++) sendBit(1'b1, 1'b1);
    sendBit(1'b1, 0); sendBit(1'b1, 0); sendBit(1'b1, 0);
    sendBit(1'b1, 1); sendBit(1'b1, 1); sendBit(1'b1, 1); sendBit(1'b1, 0); sendBit(1'b1, 1);
    checkVal("R8", "late leader locks", int'(syncFound), 1);
    checkVal("R8", "late leader no error", int'(syncErr), 0);
    sendByte(8'h5A);
    checkVal("R8", "byte after late lock", int'(byteOut), 8'h5A);
    idle(2);

    // Random bursts checked against the model (R5 main function)
    phaseTag = "R5";
    for (int burst = 0; burst < 80; burst++) begin
      int nz, ng, nb, np;
      nz = int'($urandom_range(0, 20));
      ng = ($urandom_range(0, 3) == 0) ? int'($urandom_range(1, 40)) : 0;
      nb = int'($urandom_range(0, 6));
      np = int'($urandom_range(0, 7));
      sendZeros(nz);
      for (int i = 0; i < ng; i++) sendBit(1'b1, 1'($urandom_range(0, 1)));
      sendLeader();
      for (int i = 0; i < nb; i++) sendByte(8'($urandom_range(0, 255)));
      for (int i = 0; i < np; i++) sendBit(1'b1, 1'($urandom_range(0, 1)));
      idle(int'($urandom_range(1, 3)));
    end

    finishRun();
  end
endmodule